// File: doc/BRIEF.md
# Connection Memory Bulk Initializer

This block loads one value into every word of a switch connection memory in a single pass, so software does not have to write each location. A 16-bit control word, written and read through a simple register port, holds a 3-bit fill pattern, a fill-mode bit and a go bit. When a control write sets both the mode bit and the go bit, the block walks the whole memory, one word per clock. Each word gets the pattern in its top three bits and zero everywhere else. When the last word has been written, the block clears the go bit by itself.

The memory behind the block has a single write port. The block drives that port both for the sweep and for ordinary host writes. A host write that arrives during a sweep is held off by a ready signal until the sweep is over. With the default sizes there are 32 streams of 256 channels, which makes 8192 words. A sweep therefore takes 8192 clocks. At 125 MHz that is well inside two 125 us frame periods.

Top module: `cm_bulk_init`

## Requirements
- R1: After reset the control word reads 0x0000, no memory write is driven and hostReady is high.
- R2: A control write with bit 0 (fill mode) and bit 1 (go) both set starts a sweep on the next clock. The sweep drives memWe on 2^(STREAM_W+CHAN_W) consecutive clocks, with memAddr = {stream, channel} running from 0 up to the last address in ascending order.
- R3: Every word written by a sweep carries control bits 15:13 in memData bits 15:13, and zero in memData bits 12:0.
- R4: On the clock after the last sweep write, control bit 1 (go) reads 0. The other control bits keep the values they had.
- R5: A control write with bit 1 set and bit 0 clear starts no sweep, writes no memory word, and leaves bit 1 reading back as 1.
- R6: hostReady is low for the whole sweep. A host write request held during the sweep is not passed to the memory until the sweep ends, and is then passed exactly once with its own address and data.
- R7: While no sweep runs, a host write request with hostReady high drives memWe, memAddr and memData from the host inputs in the same cycle.
- R8: Control writes made during a sweep are ignored. They change neither the sweep data nor the control word read back after the sweep.
- R9: A sweep never spans more than two frameStart pulses.
- R10: When idle, the control word reads back exactly as last written, including bits 12:2.

Ports are listed below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | DATA_W | Control word write value |
| cfgRdData | output | DATA_W | Control word read value |
| frameStart | input | 1 | One-clock pulse at each frame boundary |
| hostWrReq | input | 1 | Host memory write request |
| hostAddr | input | STREAM_W+CHAN_W | Host write address {stream, channel} |
| hostData | input | DATA_W | Host write data |
| hostReady | output | 1 | High when a host write is accepted |
| memWe | output | 1 | Memory write enable |
| memAddr | output | STREAM_W+CHAN_W | Memory write address |
| memData | output | DATA_W | Memory write data |

## Verification
The scoreboard expects every address of each sweep in order, followed by any stalled host write. A sweep that skipped, repeated or reordered a word, or that let a host write slip into the middle, fails on the first mismatched item. The bench samples the go bit one clock before and one clock after the last write. An off-by-one sweep length, or a go bit that never clears, shows up as a wrong readback. Two further cases are a go bit written with fill mode low, which must cause no write at all, and a control write made mid-sweep, which must not alter the pattern or the stored word. Both are caught by an unexpected write or by a changed readback.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
  // control word bit positions
  localparam int MODE_BIT = 0;
  localparam int GO_BIT   = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // restart the sweep address
    logic run;   // sweep in progress, own the memory port
  } cmi_strobe_t;
endpackage

// File: rtl/cmi_ctrl.sv
module cmi_ctrl
  import cmi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              frameStart,
  input  logic              sweepLast,
  output logic [PAT_W-1:0]  fillPat,
  output cmi_strobe_t       strobe
);
  logic [DATA_W-1:0] ctrlWord;
  logic              busy;
  logic [1:0]        frmCnt;
  logic              startReq;

  assign startReq   = cfgWrEn && !busy && cfgWrData[MODE_BIT] && cfgWrData[GO_BIT];
  assign strobe.load = startReq;
  assign strobe.run  = busy;
  assign fillPat    = ctrlWord[DATA_W-1 -: PAT_W];
  assign cfgRdData  = ctrlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      busy     <= 1'b0;
    end else if (busy) begin
      if (sweepLast) begin
        busy             <= 1'b0;
        ctrlWord[GO_BIT] <= 1'b0;
      end
    end else if (cfgWrEn) begin
      ctrlWord <= cfgWrData;
      busy     <= startReq;
    end
  end

  // frame pulses seen during the current sweep (saturating)
  always_ff @(posedge clk) begin
    if (!rstN || startReq) frmCnt <= '0;
    else if (busy && frameStart && frmCnt != 2'd3) frmCnt <= frmCnt + 2'd1;
  end

  p_go_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy && sweepLast |=> !ctrlWord[GO_BIT] && !busy);
  p_ignore_cfg_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && cfgWrEn |=> $stable(fillPat) && $stable(ctrlWord[DATA_W-1:GO_BIT+1]));
  p_no_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cfgWrEn && !cfgWrData[MODE_BIT] |=> !busy);
  p_two_frames_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> frmCnt <= 2'd2);
endmodule

// File: rtl/cmi_dp.sv
module cmi_dp
  import cmi_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int PAT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmi_strobe_t       strobe,
  input  logic [PAT_W-1:0]  fillPat,
  output logic              sweepLast,
  input  logic              hostWrReq,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  output logic              hostReady,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam int ZERO_W = DATA_W - PAT_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic [ADDR_W-1:0] sweepAddr;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.load) sweepAddr <= '0;
    else if (strobe.run)      sweepAddr <= sweepAddr + 1'b1;
  end

  assign sweepLast = strobe.run && (sweepAddr == LAST_ADDR);
  assign hostReady = !strobe.run;
  assign memWe     = strobe.run || hostWrReq;
  assign memAddr   = strobe.run ? sweepAddr : hostAddr;
  assign memData   = strobe.run ? {fillPat, {ZERO_W{1'b0}}} : hostData;

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run && !sweepLast |=> memWe && memAddr == $past(memAddr) + 1'b1);
  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> memData[ZERO_W-1:0] == '0);
  p_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run && hostWrReq |-> !hostReady);
  p_host_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostReady && hostWrReq |-> memWe && memAddr == hostAddr && memData == hostData);
endmodule

// File: rtl/cm_bulk_init.sv
module cm_bulk_init
  import cmi_pkg::*;
#(
  parameter int STREAM_W = 5,
  parameter int CHAN_W   = 8,
  parameter int DATA_W   = 16,
  parameter int PAT_W    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic [DATA_W-1:0]          cfgWrData,
  output logic [DATA_W-1:0]          cfgRdData,
  input  logic                       frameStart,
  input  logic                       hostWrReq,
  input  logic [STREAM_W+CHAN_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]          hostData,
  output logic                       hostReady,
  output logic                       memWe,
  output logic [STREAM_W+CHAN_W-1:0] memAddr,
  output logic [DATA_W-1:0]          memData
);
  localparam int ADDR_W = STREAM_W + CHAN_W;

  cmi_strobe_t      strobe;
  logic             sweepLast;
  logic [PAT_W-1:0] fillPat;

  cmi_ctrl #(.DATA_W(DATA_W), .PAT_W(PAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .frameStart(frameStart), .sweepLast(sweepLast),
    .fillPat(fillPat), .strobe(strobe)
  );

  cmi_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillPat(fillPat),
    .sweepLast(sweepLast), .hostWrReq(hostWrReq), .hostAddr(hostAddr),
    .hostData(hostData), .hostReady(hostReady), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: tb/test_cm_bulk_init.sv
module test_cm_bulk_init;
  localparam int AW = 13;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;
  localparam int FRAME_CLKS = 15625;

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [DW-1:0] cfgWrData = '0;
  logic [DW-1:0] cfgRdData;
  logic frameStart = 1'b0;
  logic hostWrReq = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostData = '0;
  logic hostReady, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;

  int checks = 0;
  int errors = 0;
  int frmInSweep = 0;
  int maxFrm = 0;
  item_t expq[$];

  always #4 clk = ~clk;

  cm_bulk_init i_cm_bulk_init (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .frameStart(frameStart), .hostWrReq(hostWrReq),
    .hostAddr(hostAddr), .hostData(hostData), .hostReady(hostReady),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  // frame pulse generator
  int fcnt = 0;
  always @(posedge clk) begin
    fcnt <= (fcnt == FRAME_CLKS - 1) ? 0 : fcnt + 1;
    frameStart <= (fcnt == 100);
  end

  // frame counter for R9
  always @(negedge clk) begin
    if (!rstN || hostReady) frmInSweep = 0;
    else if (frameStart) begin
      frmInSweep++;
      if (frmInSweep > maxFrm) maxFrm = frmInSweep;
    end
  end

  // monitor: pop and compare every memory write
  always @(negedge clk) begin
    if (rstN && memWe) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R5/R6 unexpected write addr=%h data=%h expected none", memAddr, memData);
      end else begin
        item_t e;
        e = expq.pop_front();
        if (memAddr !== e.addr || memData !== e.data) begin
          errors++;
          $display("FAIL %s write addr=%h data=%h expected addr=%h data=%h",
                   e.req, memAddr, memData, e.addr, e.data);
        end
      end
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [DW-1:0] v);
    @(posedge clk); #1 cfgWrEn = 1'b1; cfgWrData = v;
    @(posedge clk); #1 cfgWrEn = 1'b0;
  endtask

  task automatic pushSweep(input logic [2:0] pat);
    for (int a = 0; a < WORDS; a++) begin
      item_t e;
      e.addr = a[AW-1:0];
      e.data = {pat, 13'b0};
      e.req = "R2/R3 sweep";
      expq.push_back(e);
    end
  endtask

  task automatic hostWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    item_t e;
    e.addr = a; e.data = d; e.req = req;
    expq.push_back(e);
    @(posedge clk); #1 hostWrReq = 1'b1; hostAddr = a; hostData = d;
    do @(negedge clk); while (!hostReady);
    @(posedge clk); #1 hostWrReq = 1'b0;
  endtask

  // sweep with a mid-sweep host write and a mid-sweep control write
  task automatic runSweep(input logic [DW-1:0] word, input logic [AW-1:0] hA, input logic [DW-1:0] hD);
    pushSweep(word[15:13]);
    cfgWrite(word);
    fork
      begin
        repeat (WORDS - 1) @(posedge clk);
        @(negedge clk);
        check("R4 go still set before last write", {15'b0, cfgRdData[1]}, 16'd1);
        check("R6 hostReady low during sweep", {15'b0, hostReady}, 16'd0);
        @(posedge clk);
        @(negedge clk);
        check("R4 go cleared after sweep", cfgRdData, word & ~16'h0002);
      end
      begin
        repeat (50) @(posedge clk);
        cfgWrite(16'h0000);  // R8: ignored
        hostWrite(hA, hD, "R6 stalled host write");
      end
    join
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 reset control word", cfgRdData, 16'h0000);
    check("R1 reset hostReady", {15'b0, hostReady}, 16'd1);
    check("R1 reset memWe", {15'b0, memWe}, 16'd0);

    hostWrite(13'h0123, 16'hBEEF, "R7 idle host write");
    hostWrite(13'h1FFF, 16'h1234, "R7 idle host write");

    cfgWrite(16'h6ABE);  // go set, mode clear
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R5 go kept without mode", cfgRdData, 16'h6ABE);
    check("R10 readback of stored word", cfgRdData, 16'h6ABE);
    check("R5 no sweep started", {15'b0, hostReady}, 16'd1);

    runSweep(16'hA003, 13'h0042, 16'h5555);
    check("R8 word after ignored write", cfgRdData, 16'hA001);
    runSweep(16'h4FFF, 13'h1000, 16'hAAAA);
    check("R8 word after second sweep", cfgRdData, 16'h4FFD);

    repeat (5) @(posedge clk);
    check("R2 all expected writes seen", expq.size(), 16'd0);
    check("R9 frame pulses per sweep", maxFrm, (maxFrm <= 2) ? maxFrm : 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule